// File: doc/BRIEF.md
# Multisample Depth Test and Resolve

This block owns the sample storage for a small group of screen pixels. Each pixel keeps one color and one depth for every subsample. A rasterizer sends one fragment at a time. A fragment gives the target pixel, a coverage mask, a depth at the pixel's origin sample, two signed depth slopes and a single RGBA color. The block works out the depth of each subsample from the slopes and tests every covered subsample against its stored depth. A subsample that passes takes the fragment's color and its own depth.

Once all subsamples have been visited, the block averages the pixel's subsample colors, one component at a time. If at least one subsample changed, it writes that average to the displayable buffer through a one-cycle write strobe. The sample count parameter sets the storage widths. With 8 subsamples a pixel uses 12-bit components and 32-bit depths. With 16 subsamples it uses 8-bit components and 24-bit depths. Reset clears every sample: the depth goes to full scale and the color to zero. The reset is asserted asynchronously and released through a two-flop synchronizer.

Top module: `msaa_depth_resolve`

## Requirements
- R1: After reset, `busy` and `disp_wr` are low, every stored depth holds the all-ones value and every stored color component is zero.
- R2: The depth of subsample i is `zbase + dzdx*(i mod 4) + dzdy*(i div 4)`. It is computed in signed arithmetic and then saturated to the range 0 to 2^DW-1, where DW is 32 for 8 samples and 24 for 16 samples.
- R3: A subsample whose mask bit (bit i for subsample i) is 0 is not tested, and its stored color and depth stay as they were.
- R4: A covered subsample passes only when its computed depth is strictly less than its stored depth. A depth equal to the stored one fails.
- R5: A passing subsample stores the fragment color and its computed depth.
- R6: If any subsample passed, the block writes the average to the display port. For each component, the average is the sum of all subsample values shifted right by log2(SAMPLES). Color is packed with component 3 in the top bits and component 0 in the lowest CW bits, where CW is 12 for 8 samples and 8 for 16 samples.
- R7: If no subsample passed, `disp_wr` stays low for that fragment.
- R8: A fragment is accepted on a clock edge where `frag_valid` is high and `busy` is low. `busy` then stays high for exactly SAMPLES+1 cycles, and any `frag_valid` seen while busy is ignored.
- R9: `disp_wr` rises on the same edge at which `busy` falls. It lasts one cycle, and `disp_pixel` carries the fragment's pixel address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frag_valid | input | 1 | Fragment offered this cycle |
| frag_pixel | input | PIX_W | Target pixel address |
| frag_mask | input | SAMPLES | Coverage bit per subsample |
| frag_zbase | input | DW | Depth at subsample 0 |
| frag_dzdx | input | SLOPE_W | Signed depth change per column step |
| frag_dzdy | input | SLOPE_W | Signed depth change per row step |
| frag_rgba | input | 4*CW | Fragment color |
| busy | output | 1 | Fragment in progress; new fragments ignored |
| disp_wr | output | 1 | Display buffer write strobe |
| disp_pixel | output | PIX_W | Display write address |
| disp_rgba | output | 4*CW | Averaged pixel color |

## Verification
The resolve write for one fragment and the acceptance of the next can fall on the same cycle, because `disp_wr` is high in the first idle cycle. The bench provokes overlap in a different way: it offers a second fragment in the middle of a busy window. It then judges the result from the display port, by sending a probe fragment whose pass or fail outcome depends on whether the stray fragment was absorbed. Each fragment's resolve result is compared with a sample-level reference model in the bench.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TEST, ST_RESOLVE} zs_state_e;

  function automatic int comp_width(input int samples);
    return (samples == 16) ? 8 : 12;
  endfunction

  function automatic int depth_width(input int samples);
    return (samples == 16) ? 24 : 32;
  endfunction
endpackage

// File: rtl/zs_depth_calc.sv
module zs_depth_calc #(
  parameter int DW      = 32,
  parameter int SLOPE_W = 16,
  parameter int IDX_W   = 3
) (
  input  logic [IDX_W-1:0]          idx,
  input  logic [DW-1:0]             zbase,
  input  logic signed [SLOPE_W-1:0] dzdx,
  input  logic signed [SLOPE_W-1:0] dzdy,
  output logic [DW-1:0]             z
);
  localparam int EW = DW + SLOPE_W + 4;

  logic [IDX_W-1:0]     col_u, row_u;
  logic signed [EW-1:0] sx, sy, cv, rv, zb, sum, zmax;

  always_comb begin
    col_u = idx & IDX_W'(3);
    row_u = idx >> 2;
    sx    = EW'(dzdx);
    sy    = EW'(dzdy);
    cv    = $signed({{(EW-IDX_W){1'b0}}, col_u});
    rv    = $signed({{(EW-IDX_W){1'b0}}, row_u});
    zb    = $signed({{(EW-DW){1'b0}}, zbase});
    zmax  = $signed({{(EW-DW){1'b0}}, {DW{1'b1}}});
    sum   = zb + sx * cv + sy * rv;
    if (sum < 0)
      z = '0;
    else if (sum > zmax)
      z = '1;
    else
      z = sum[DW-1:0];
  end
endmodule

// File: rtl/zs_sample_store.sv
module zs_sample_store #(
  parameter int PIXELS  = 16,
  parameter int SAMPLES = 8,
  parameter int CW      = 12,
  parameter int DW      = 32,
  localparam int PIX_W  = $clog2(PIXELS),
  localparam int IDX_W  = $clog2(SAMPLES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PIX_W-1:0]          pix,
  input  logic [IDX_W-1:0]          idx,
  input  logic                      wr_en,
  input  logic [4*CW-1:0]           wr_rgba,
  input  logic [DW-1:0]             wr_depth,
  output logic [DW-1:0]             rd_depth,
  output logic [SAMPLES*4*CW-1:0]   pix_colors
);
  logic [DW-1:0]   depth_q [PIXELS][SAMPLES];
  logic [4*CW-1:0] color_q [PIXELS][SAMPLES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PIXELS; p++) begin
        for (int s = 0; s < SAMPLES; s++) begin
          depth_q[p][s] <= '1;
          color_q[p][s] <= '0;
        end
      end
    end else if (wr_en) begin
      depth_q[pix][idx] <= wr_depth;
      color_q[pix][idx] <= wr_rgba;
    end
  end

  assign rd_depth = depth_q[pix][idx];

  for (genvar s = 0; s < SAMPLES; s++) begin : g_rd
    assign pix_colors[s*4*CW +: 4*CW] = color_q[pix][s];
  end

  AST_DEPTH_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_depth < rd_depth)); // R4
endmodule

// File: rtl/zs_box_resolve.sv
module zs_box_resolve #(
  parameter int SAMPLES = 8,
  parameter int CW      = 12,
  localparam int LOG2S  = $clog2(SAMPLES),
  localparam int SUMW   = CW + LOG2S
) (
  input  logic [SAMPLES*4*CW-1:0] pix_colors,
  output logic [4*CW-1:0]         avg_rgba
);
  for (genvar c = 0; c < 4; c++) begin : g_comp
    logic [SUMW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int s = 0; s < SAMPLES; s++)
        acc = acc + SUMW'(pix_colors[s*4*CW + c*CW +: CW]);
    end
    assign avg_rgba[c*CW +: CW] = acc[SUMW-1:LOG2S];
  end
endmodule

// File: rtl/msaa_depth_resolve.sv
module msaa_depth_resolve
  import zs_pkg::*;
#(
  parameter int SAMPLES  = 8,
  parameter int PIXELS   = 16,
  parameter int SLOPE_W  = 16,
  localparam int CW      = comp_width(SAMPLES),
  localparam int DW      = depth_width(SAMPLES),
  localparam int IDX_W   = $clog2(SAMPLES),
  localparam int PIX_W   = $clog2(PIXELS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frag_valid,
  input  logic [PIX_W-1:0]          frag_pixel,
  input  logic [SAMPLES-1:0]        frag_mask,
  input  logic [DW-1:0]             frag_zbase,
  input  logic signed [SLOPE_W-1:0] frag_dzdx,
  input  logic signed [SLOPE_W-1:0] frag_dzdy,
  input  logic [4*CW-1:0]           frag_rgba,
  output logic                      busy,
  output logic                      disp_wr,
  output logic [PIX_W-1:0]          disp_pixel,
  output logic [4*CW-1:0]           disp_rgba
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  zs_state_e                  state_q, state_d;
  logic [IDX_W-1:0]           idx_q, idx_d;
  logic [PIX_W-1:0]           pix_q;
  logic [SAMPLES-1:0]         mask_q;
  logic [DW-1:0]              zb_q;
  logic signed [SLOPE_W-1:0]  dx_q, dy_q;
  logic [4*CW-1:0]            rgba_q;
  logic                       any_q, any_d;
  logic                       load_en;
  logic                       disp_wr_d, disp_en;

  logic [DW-1:0]              z_sample, z_stored;
  logic                       wr_en;
  logic [SAMPLES*4*CW-1:0]    pix_colors;
  logic [4*CW-1:0]            avg_rgba;

  zs_depth_calc #(.DW(DW), .SLOPE_W(SLOPE_W), .IDX_W(IDX_W)) u_calc (
    .idx   (idx_q),
    .zbase (zb_q),
    .dzdx  (dx_q),
    .dzdy  (dy_q),
    .z     (z_sample)
  );

  zs_sample_store #(.PIXELS(PIXELS), .SAMPLES(SAMPLES), .CW(CW), .DW(DW)) u_store (
    .clk        (clk),
    .rst_n      (rst_ni),
    .pix        (pix_q),
    .idx        (idx_q),
    .wr_en      (wr_en),
    .wr_rgba    (rgba_q),
    .wr_depth   (z_sample),
    .rd_depth   (z_stored),
    .pix_colors (pix_colors)
  );

  zs_box_resolve #(.SAMPLES(SAMPLES), .CW(CW)) u_resolve (
    .pix_colors (pix_colors),
    .avg_rgba   (avg_rgba)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    any_d     = any_q;
    load_en   = 1'b0;
    wr_en     = 1'b0;
    disp_wr_d = 1'b0;
    disp_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (frag_valid) begin
          load_en = 1'b1;
          idx_d   = '0;
          any_d   = 1'b0;
          state_d = ST_TEST;
        end
      end
      ST_TEST: begin
        wr_en = mask_q[idx_q] && (z_sample < z_stored);
        if (wr_en) any_d = 1'b1;
        if (idx_q == IDX_W'(SAMPLES - 1)) state_d = ST_RESOLVE;
        else                              idx_d   = idx_q + IDX_W'(1);
      end
      ST_RESOLVE: begin
        disp_wr_d = any_q;
        disp_en   = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      any_q   <= 1'b0;
      disp_wr <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      any_q   <= any_d;
      disp_wr <= disp_wr_d;
    end
  end

  // fragment capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q  <= '0;
      mask_q <= '0;
      zb_q   <= '0;
      dx_q   <= '0;
      dy_q   <= '0;
      rgba_q <= '0;
    end else if (load_en) begin
      pix_q  <= frag_pixel;
      mask_q <= frag_mask;
      zb_q   <= frag_zbase;
      dx_q   <= frag_dzdx;
      dy_q   <= frag_dzdy;
      rgba_q <= frag_rgba;
    end
  end

  // display port, enabled in the resolve cycle
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_pixel <= '0;
      disp_rgba  <= '0;
    end else if (disp_en) begin
      disp_pixel <= pix_q;
      disp_rgba  <= avg_rgba;
    end
  end

  assign busy = (state_q != ST_IDLE);

  AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy) |-> $past(frag_valid)); // R8
  AST_DISP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
    disp_wr |=> !disp_wr); // R9
  AST_DISP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    disp_wr |-> !busy); // R9
  AST_DISP_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_ni)
    disp_wr |-> $past(any_q)); // R7
endmodule

// File: tb/tb_msaa_depth_resolve.sv
module tb_msaa_depth_resolve;
  localparam int S  = 8;
  localparam int CW = 12;
  localparam int DW = 32;
  localparam int NP = 16;
  localparam int NV = 9;
  // vector: pixel[124:121] mask[120:113] z[112:81] dzdx[80:65] dzdy[64:49] rgba[48:1] exp_wr[0]
  localparam logic [47:0] CA = {12'd800, 12'd400, 12'd200, 12'd80};
  localparam logic [47:0] CB = {12'd16, 12'd32, 12'd64, 12'd4000};
  localparam logic [47:0] CC = {12'd4095, 12'd7, 12'd1000, 12'd333};
  localparam logic [124:0] VEC [NV] = '{
    {4'd3, 8'hFF, 32'd1000,       16'h0000, 16'h0000, CA, 1'b1},
    {4'd3, 8'h0F, 32'd2000,       16'h0000, 16'h0000, CB, 1'b0},
    {4'd3, 8'h0F, 32'd500,        16'h000A, 16'h0000, CB, 1'b1},
    {4'd3, 8'hF0, 32'd1000,       16'h0000, 16'h0000, CC, 1'b0},
    {4'd5, 8'h81, 32'd100,        16'hFFCE, 16'h0000, CC, 1'b1},
    {4'd5, 8'h80, 32'd0,          16'h0000, 16'h0000, CA, 1'b0},
    {4'd5, 8'h00, 32'd0,          16'h0000, 16'h0000, CA, 1'b0},
    {4'd9, 8'hFF, 32'hFFFF_FFF0,  16'h0000, 16'h0010, CB, 1'b1},
    {4'd9, 8'hF0, 32'hFFFF_FFFE,  16'h0000, 16'h0000, CC, 1'b1}
  };

  logic              clk, rst_n, frag_valid;
  logic [3:0]        frag_pixel;
  logic [7:0]        frag_mask;
  logic [31:0]       frag_zbase;
  logic signed [15:0] frag_dzdx, frag_dzdy;
  logic [47:0]       frag_rgba;
  logic              busy, disp_wr;
  logic [3:0]        disp_pixel;
  logic [47:0]       disp_rgba;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mdep [NP][S];
  logic [47:0] mcol [NP][S];

  msaa_depth_resolve dut (
    .clk(clk), .rst_n(rst_n), .frag_valid(frag_valid), .frag_pixel(frag_pixel),
    .frag_mask(frag_mask), .frag_zbase(frag_zbase), .frag_dzdx(frag_dzdx),
    .frag_dzdy(frag_dzdy), .frag_rgba(frag_rgba), .busy(busy), .disp_wr(disp_wr),
    .disp_pixel(disp_pixel), .disp_rgba(disp_rgba)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_z(input logic [31:0] z, input logic signed [15:0] dx,
                                          input logic signed [15:0] dy, input int i);
    longint v;
    v = longint'({32'b0, z}) + longint'(dx) * (i % 4) + longint'(dy) * (i / 4);
    if (v < 0) return 32'd0;
    if (v > 64'sh0000_0000_FFFF_FFFF) return 32'hFFFF_FFFF;
    return v[31:0];
  endfunction

  function automatic logic [47:0] model_avg(input int p);
    logic [47:0] r;
    for (int c = 0; c < 4; c++) begin
      int sum = 0;
      for (int s = 0; s < S; s++) sum += int'(mcol[p][s][c*CW +: CW]);
      r[c*CW +: CW] = 12'(sum >> 3);
    end
    return r;
  endfunction

  task automatic run_frag(input logic [3:0] p, input logic [7:0] m, input logic [31:0] z,
                          input logic signed [15:0] dx, input logic signed [15:0] dy,
                          input logic [47:0] col, input bit exp_wr, input bit inject);
    int busy_cycles = 0;
    frag_pixel = p; frag_mask = m; frag_zbase = z;
    frag_dzdx = dx; frag_dzdy = dy; frag_rgba = col; frag_valid = 1'b1;
    @(negedge clk);
    frag_valid = 1'b0;
    for (int s = 0; s < S; s++) begin
      logic [31:0] zs;
      zs = model_z(z, dx, dy, s);
      if (m[s] && zs < mdep[p][s]) begin
        mdep[p][s] = zs;
        mcol[p][s] = col;
      end
    end
    while (busy && busy_cycles < 100) begin
      busy_cycles++;
      if (inject && busy_cycles == 3) begin
        frag_pixel = 4'd12; frag_mask = 8'hFF; frag_zbase = 32'd0;
        frag_dzdx = 16'sd0; frag_dzdy = 16'sd0; frag_rgba = CC; frag_valid = 1'b1;
      end
      if (inject && busy_cycles == 4) frag_valid = 1'b0;
      @(negedge clk);
    end
    check(busy_cycles == S + 1, "R8 busy length", 64'(busy_cycles), 64'(S + 1));
    check(disp_wr == exp_wr, "R3/R4/R7 display write", 64'(disp_wr), 64'(exp_wr));
    if (exp_wr) begin
      check(disp_pixel == p, "R9 display pixel", 64'(disp_pixel), 64'(p));
      check(disp_rgba == model_avg(p), "R2/R5/R6 resolved color", 64'(disp_rgba), 64'(model_avg(p)));
    end
    @(negedge clk);
    check(disp_wr == 1'b0, "R9 single-cycle strobe", 64'(disp_wr), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < S; s++) begin
        mdep[p][s] = 32'hFFFF_FFFF;
        mcol[p][s] = '0;
      end
    rst_n = 1'b0; frag_valid = 1'b0; frag_pixel = '0; frag_mask = '0;
    frag_zbase = '0; frag_dzdx = '0; frag_dzdy = '0; frag_rgba = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle after reset
    check(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
    check(disp_wr == 1'b0, "R1 disp_wr after reset", 64'(disp_wr), 64'd0);

    for (int v = 0; v < NV; v++)
      run_frag(VEC[v][124:121], VEC[v][120:113], VEC[v][112:81], VEC[v][80:65],
               VEC[v][64:49], VEC[v][48:1], VEC[v][0], 1'b0);

    // R1: untouched pixel is cleared; one covered sample shows the zero neighbours
    run_frag(4'd14, 8'h04, 32'hFFFF_FFFE, 16'sd0, 16'sd0, CC, 1'b1, 1'b0);

    // R8: a fragment offered mid-window to pixel 12 must be ignored
    run_frag(4'd7, 8'h3C, 32'd50, 16'sd3, 16'sd7, CA, 1'b1, 1'b1);
    // probe pixel 12: passes only if the stray fragment was dropped
    run_frag(4'd12, 8'h01, 32'd5, 16'sd0, 16'sd0, CB, 1'b1, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule